// File: doc/BRIEF.md
# Synchronous Serial Port Status Flag Unit

This block holds the status flags of a synchronous serial port. The transmit and receive engines, frame-sync detector and compare matchers that surround it signal their activity as single-cycle pulses or as level signals. The block tracks how full the transmit holding and shift registers are and how full the receive holding register is. It records enable state, readiness, emptiness, overrun, frame-sync events and two compare-match events.

Software reads the collected flags as one 32-bit status word over a simple read bus. The read data appears one cycle after the request. The event flags are sticky: each stays set until the status word is read. The enable flags do not drop as soon as a disable command arrives. Each one waits until its path has gone idle.

Top module: `ssp_status_flags`

## Requirements
- R1: After the synchronous active-high reset, both enables and all sticky flags are clear and all three data registers count as empty, so the status word reads 0x00000003.
- R2: Receive-enable (bit 17) sets on `cmd_rx_on`. After `cmd_rx_off` it clears on the first clock edge at which `rx_busy` is low. While `rx_busy` stays high, the clear waits.
- R3: Transmit-enable (bit 16) sets on `cmd_tx_on`. After `cmd_tx_off` it clears on the first clock edge at which both the transmit holding register and the shift register are empty.
- R4: Receive-sync (bit 11) and transmit-sync (bit 10) set on their event pulses and clear when the status word is read.
- R5: Compare-0 (bit 8) and compare-1 (bit 9) set on their event pulses and clear when the status word is read.
- R6: Overrun (bit 5) sets when a word is loaded into a full receive holding register that is not read in the same cycle. It clears when the status word is read.
- R7: Receive-ready (bit 4) is high from a receive load until the holding register is read. A load in the same cycle as a read keeps it high.
- R8: Transmit-ready (bit 0) is high while the transmit holding register is empty. Transmit-empty (bit 1) is high only while both the holding and the shift registers are empty.
- R9: A read at offset 0x40 returns the status word on `rd_data` one cycle later, and all unused bits read as zero. A read at any other offset returns zero and clears nothing.
- R10: An event pulse in the same cycle as a status read leaves its flag set afterwards.
- R11: An enable command and a disable command for the same path in the same cycle leave that path enabled, with no disable pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_rx_on | input | 1 | Receive-enable command pulse |
| cmd_rx_off | input | 1 | Receive-disable command pulse |
| cmd_tx_on | input | 1 | Transmit-enable command pulse |
| cmd_tx_off | input | 1 | Transmit-disable command pulse |
| rx_busy | input | 1 | Level: receive data is being processed |
| rx_load | input | 1 | Pulse: received word loaded into receive holding register |
| rx_rd | input | 1 | Pulse: receive holding register read |
| tx_wr | input | 1 | Pulse: word written into transmit holding register |
| tx_load | input | 1 | Pulse: holding register moved into shift register |
| tx_done | input | 1 | Pulse: shift register finished sending |
| rx_sync_ev | input | 1 | Receive frame-sync event pulse |
| tx_sync_ev | input | 1 | Transmit frame-sync event pulse |
| cmp0_ev | input | 1 | Compare-0 match pulse |
| cmp1_ev | input | 1 | Compare-1 match pulse |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data, valid one cycle after the request |

## Verification
The status read and a flag-setting event can fall in the same cycle, and so can a receive load and a receive read. The bench raises a compare pulse in the same cycle as a status read. It expects the read to return the old word and the flag to remain set on the following read. It then pairs a receive load with a holding-register read while the register is already full. It expects receive-ready to stay high with no overrun recorded.

// File: rtl/ssp_status_flags.sv
module ssp_status_flags #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_rx_on,
  input  logic              cmd_rx_off,
  input  logic              cmd_tx_on,
  input  logic              cmd_tx_off,
  input  logic              rx_busy,
  input  logic              rx_load,
  input  logic              rx_rd,
  input  logic              tx_wr,
  input  logic              tx_load,
  input  logic              tx_done,
  input  logic              rx_sync_ev,
  input  logic              tx_sync_ev,
  input  logic              cmp0_ev,
  input  logic              cmp1_ev,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data
);

  logic rx_en, rx_off_pend, tx_en, tx_off_pend;
  logic rx_full, tx_hold_full, tx_shift_full;
  logic ovr, rx_syn, tx_syn, cp0, cp1;
  logic status_rd, tx_idle, tx_move;
  logic [31:0] status_word;

  assign status_rd = rd_en && (rd_addr == STATUS_OFS);
  assign tx_idle   = !tx_hold_full && !tx_shift_full;
  assign tx_move   = tx_load && tx_hold_full;

  always_comb begin
    status_word     = '0;
    status_word[0]  = !tx_hold_full;
    status_word[1]  = tx_idle;
    status_word[4]  = rx_full;
    status_word[5]  = ovr;
    status_word[8]  = cp0;
    status_word[9]  = cp1;
    status_word[10] = tx_syn;
    status_word[11] = rx_syn;
    status_word[16] = tx_en;
    status_word[17] = rx_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_full       <= 1'b0;
      tx_hold_full  <= 1'b0;
      tx_shift_full <= 1'b0;
    end else begin
      rx_full       <= (rx_full && !rx_rd) || rx_load;
      tx_hold_full  <= (tx_hold_full && !tx_load) || tx_wr;
      tx_shift_full <= (tx_shift_full && !tx_done) || tx_move;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr    <= 1'b0;
      rx_syn <= 1'b0;
      tx_syn <= 1'b0;
      cp0    <= 1'b0;
      cp1    <= 1'b0;
    end else begin
      ovr    <= (rx_load && rx_full && !rx_rd) || (ovr && !status_rd);
      rx_syn <= rx_sync_ev || (rx_syn && !status_rd);
      tx_syn <= tx_sync_ev || (tx_syn && !status_rd);
      cp0    <= cmp0_ev || (cp0 && !status_rd);
      cp1    <= cmp1_ev || (cp1 && !status_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en       <= 1'b0;
      rx_off_pend <= 1'b0;
    end else if (cmd_rx_on) begin
      rx_en       <= 1'b1;
      rx_off_pend <= 1'b0;
    end else if ((rx_off_pend || cmd_rx_off) && !rx_busy) begin
      rx_en       <= 1'b0;
      rx_off_pend <= 1'b0;
    end else if (cmd_rx_off) begin
      rx_off_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en       <= 1'b0;
      tx_off_pend <= 1'b0;
    end else if (cmd_tx_on) begin
      tx_en       <= 1'b1;
      tx_off_pend <= 1'b0;
    end else if ((tx_off_pend || cmd_tx_off) && tx_idle) begin
      tx_en       <= 1'b0;
      tx_off_pend <= 1'b0;
    end else if (cmd_tx_off) begin
      tx_off_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= status_rd ? status_word : '0;
  end

endmodule

module ssp_status_flags_chk (
  input logic        clk,
  input logic        rst,
  input logic        status_rd,
  input logic [31:0] word,
  input logic [31:0] rd_data,
  input logic        cmd_rx_on,
  input logic        rx_busy,
  input logic        rx_load,
  input logic        rx_rd,
  input logic        rx_sync_ev,
  input logic        cmp0_ev
);
  localparam logic [31:0] USED = 32'h0003_0F33;

  // R2
  rxen_on_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_rx_on |=> word[17]);

  // R2
  rxen_fall_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(word[17]) |-> !$past(rx_busy));

  // R4
  rxsyn_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !rx_sync_ev) |=> !word[11]);

  // R5
  cp0_set_chk: assert property (@(posedge clk) disable iff (rst)
    cmp0_ev |=> word[8]);

  // R6
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_load && word[4] && !rx_rd) |=> word[5]);

  // R9
  read_word_chk: assert property (@(posedge clk) disable iff (rst)
    status_rd |=> (rd_data == $past(word)));

  // R9
  unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~USED) == 32'h0);

  // R10
  cp0_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp0_ev && status_rd) |=> word[8]);
endmodule

bind ssp_status_flags ssp_status_flags_chk u_chk (
  .clk(clk), .rst(rst), .status_rd(status_rd), .word(status_word),
  .rd_data(rd_data), .cmd_rx_on(cmd_rx_on), .rx_busy(rx_busy),
  .rx_load(rx_load), .rx_rd(rx_rd), .rx_sync_ev(rx_sync_ev),
  .cmp0_ev(cmp0_ev)
);

// File: tb/ssp_status_flags_bench.sv
module ssp_status_flags_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_rx_on = 0, cmd_rx_off = 0, cmd_tx_on = 0, cmd_tx_off = 0;
  logic rx_busy = 0, rx_load = 0, rx_rd = 0;
  logic tx_wr = 0, tx_load = 0, tx_done = 0;
  logic rx_sync_ev = 0, tx_sync_ev = 0, cmp0_ev = 0, cmp1_ev = 0;
  logic rd_en = 0;
  logic [7:0] rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0, failures = 0;
  logic rd_vld_d = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  ssp_status_flags u_ssp_status_flags (
    .clk(clk), .rst(rst),
    .cmd_rx_on(cmd_rx_on), .cmd_rx_off(cmd_rx_off),
    .cmd_tx_on(cmd_tx_on), .cmd_tx_off(cmd_tx_off),
    .rx_busy(rx_busy), .rx_load(rx_load), .rx_rd(rx_rd),
    .tx_wr(tx_wr), .tx_load(tx_load), .tx_done(tx_done),
    .rx_sync_ev(rx_sync_ev), .tx_sync_ev(tx_sync_ev),
    .cmp0_ev(cmp0_ev), .cmp1_ev(cmp1_ev),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk) rd_vld_d <= rd_en && !rst;

  // monitor: pops expected items as read data emerges
  always @(negedge clk) begin
    if (rd_vld_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        failures++;
        $display("FAIL %s: rd_data=%08h expected=%08h", t, rd_data, e);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    cmd_rx_on = 0; cmd_rx_off = 0; cmd_tx_on = 0; cmd_tx_off = 0;
    rx_load = 0; rx_rd = 0; tx_wr = 0; tx_load = 0; tx_done = 0;
    rx_sync_ev = 0; tx_sync_ev = 0; cmp0_ev = 0; cmp1_ev = 0;
    rd_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    rd_en = 1; rd_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    rd(8'h40, 32'h3, "R1 reset word"); tick();

    rx_sync_ev = 1; tx_sync_ev = 1; tick();
    rd(8'h40, 32'hC03, "R4 sync set"); tick();
    rd(8'h40, 32'h3, "R4 sync cleared by read"); tick();

    cmp0_ev = 1; tick();
    cmp1_ev = 1; tick();
    rd(8'h40, 32'h303, "R5 compare set"); tick();
    rd(8'h40, 32'h3, "R5 compare cleared"); tick();

    cmp0_ev = 1; tick();
    rd(8'h44, 32'h0, "R9 other offset reads zero"); tick();
    rd(8'h40, 32'h103, "R9 other offset clears nothing"); tick();
    rd(8'h40, 32'h3, "R9 status read clears"); tick();

    cmp1_ev = 1; tick();
    cmp1_ev = 1; rd(8'h40, 32'h203, "R10 read with event"); tick();
    rd(8'h40, 32'h203, "R10 event wins over read"); tick();
    rd(8'h40, 32'h3, "R10 later read clears"); tick();

    rx_load = 1; tick();
    rd(8'h40, 32'h13, "R7 receive ready"); tick();
    rx_load = 1; tick();
    rd(8'h40, 32'h33, "R6 overrun set"); tick();
    rd(8'h40, 32'h13, "R6 overrun cleared, ready kept"); tick();
    rx_rd = 1; tick();
    rd(8'h40, 32'h3, "R7 ready cleared by read"); tick();
    rx_load = 1; tick();
    rx_load = 1; rx_rd = 1; tick();
    rd(8'h40, 32'h13, "R6 load with read: no overrun"); tick();
    rx_rd = 1; tick();

    tx_wr = 1; tick();
    rd(8'h40, 32'h0, "R8 holding full"); tick();
    tx_load = 1; tick();
    rd(8'h40, 32'h1, "R8 shifting"); tick();
    tx_done = 1; tick();
    rd(8'h40, 32'h3, "R8 drained"); tick();

    cmd_rx_on = 1; tick();
    rd(8'h40, 32'h20003, "R2 rx enabled"); tick();
    rx_busy = 1; cmd_rx_off = 1; tick();
    rd(8'h40, 32'h20003, "R2 busy holds enable"); tick();
    rx_busy = 0; tick();
    rd(8'h40, 32'h3, "R2 rx disabled when idle"); tick();

    cmd_tx_on = 1; tx_wr = 1; tick();
    cmd_tx_off = 1; tick();
    rd(8'h40, 32'h10000, "R3 enable held, holding full"); tick();
    tx_load = 1; tick();
    rd(8'h40, 32'h10001, "R3 enable held while shifting"); tick();
    tx_done = 1; tick();
    rd(8'h40, 32'h10003, "R3 clears on first idle edge"); tick();
    rd(8'h40, 32'h3, "R3 tx disabled"); tick();

    cmd_rx_on = 1; cmd_rx_off = 1; tick();
    rd(8'h40, 32'h20003, "R11 on wins"); tick();
    rd(8'h40, 32'h20003, "R11 no pending disable"); tick();
    cmd_rx_off = 1; tick();
    rd(8'h40, 32'h3, "R11 later disable"); tick();

    tick(); tick();
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL monitor: %0d reads unanswered (expected 0)", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule